// File: doc/BRIEF.md
# Programmable Divider Phase-Step Sequencer

This block divides a reference clock by a programmable modulus and uses each divider terminal count to move a 200-position phase selector one step. The selector drives one-hot select lines for an external delay-line switch. Those lines are split into 8 coarse selects, 45 degrees apart, and 25 fine selects between adjacent coarse taps. Stepping the selector continuously through the taps moves the phase of the reference signal steadily. This shifts the smoothed output frequency up or down by a fraction that the modulus sets. The direction input chooses the sign of the shift.

A vernier block counts the terminal pulse. That vernier block supplies three signals back to this block. The first is a deletion strobe, which swallows one reference cycle and stretches the current divide period from N to N+1. The second is a carry pulse, which raises the modulus by one. The third is a borrow pulse, which lowers the modulus by one. At power-up the modulus takes a preset of 83, midway between the two operating moduli 76 and 90.

Top module: `phase_step_seq`

## Requirements
- R1: After reset, the modulus is 83, the selector is at phase 0 (coarseSel bit 0 and fineSel bit 0 set), and termPulse is low.
- R2: With no deletion strobe and a steady modulus N greater than 1, termPulse goes high for exactly one clock once every N clock cycles.
- R3: Holding swallow high for one cycle within a divide period lengthens that period to N+1 cycles.
- R4: A modInc pulse raises the modulus by one and a modDec pulse lowers it by one, both on the next clock edge. The modulus wraps modulo 128. When both pulses arrive in the same cycle, the modulus does not change.
- R5: A modulus change made part-way through a period is used at the next equality comparison, so that period already ends after the new N cycles.
- R6: With dirUp high, each terminal pulse raises the phase index by one, and the index goes from 199 back to 0.
- R7: With dirUp low, each terminal pulse lowers the phase index by one, and the index goes from 0 back to 199.
- R8: Phase index p is shown as coarseSel bit (p / 25) and fineSel bit (p mod 25). Each of the two vectors has exactly one bit set.
- R9: The select outputs change only on a cycle in which termPulse is high. The new phase appears in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| dirUp | input | 1 | Step direction: 1 advances the phase, 0 retards it |
| swallow | input | 1 | Deletion strobe that blocks one reference cycle from the divider |
| modInc | input | 1 | Carry pulse that raises the modulus by one |
| modDec | input | 1 | Borrow pulse that lowers the modulus by one |
| termPulse | output | 1 | One-cycle divider terminal pulse |
| modVal | output | 7 | Current modulus |
| coarseSel | output | 8 | One-hot coarse tap select |
| fineSel | output | 25 | One-hot fine tap select |

## Verification
The bench builds the block with its default parameters. These are a 7-bit modulus preset to 83, 8 coarse taps and 25 fine taps, so the full 200-position wrap is covered in both directions. With a modulus near 83, one full lap of the selector costs only about 16,600 cycles. Every step that crosses a coarse boundary is therefore reachable, including the carry from fine 24 into the next coarse tap and the borrow from phase 0 to phase 199. Divide periods are measured as cycle counts between pulses, so a one-cycle stretch or a one-step modulus change shows up as an exact difference.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Strobe bundle from divider control to phase datapath
  typedef struct packed {
    logic step;  // selector moves this cycle
    logic up;    // direction of that move
  } stepCmd_t;
endpackage

// File: rtl/pss_divider.sv
module pss_divider
  import pss_pkg::*;
#(
  parameter int MOD_W      = 7,
  parameter int MOD_PRESET = 83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dirUp,
  input  logic             swallow,
  input  logic             modInc,
  input  logic             modDec,
  output stepCmd_t         cmd,
  output logic             termPulse,
  output logic [MOD_W-1:0] modVal
);
  localparam logic [MOD_W-1:0] PRESET_V = MOD_W'(MOD_PRESET);

  logic [MOD_W-1:0] cnt;
  logic [MOD_W-1:0] cntNext;
  logic [MOD_W-1:0] modReg;
  logic             hit;

  // The divider compares its value in every bit with the modulus register.
  // The swallow strobe blocks the cycle, so no count and no compare happen.
  assign cntNext = cnt + 1'b1;
  assign hit     = !swallow && (cntNext == modReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      termPulse <= 1'b0;
      modReg    <= PRESET_V;
    end else begin
      if (!swallow) cnt <= hit ? '0 : cntNext;
      termPulse <= hit;
      unique case ({modInc, modDec})
        2'b10:   modReg <= modReg + 1'b1;
        2'b01:   modReg <= modReg - 1'b1;
        default: modReg <= modReg;
      endcase
    end
  end

  assign cmd.step = hit;
  assign cmd.up   = dirUp;
  assign modVal   = modReg;
endmodule

// File: rtl/pss_phase.sv
module pss_phase
  import pss_pkg::*;
#(
  parameter int COARSE_N = 8,
  parameter int FINE_N   = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stepCmd_t            cmd,
  output logic [COARSE_N-1:0] coarseSel,
  output logic [FINE_N-1:0]   fineSel
);
  localparam int CW = (COARSE_N > 1) ? $clog2(COARSE_N) : 1;
  localparam int FW = (FINE_N > 1) ? $clog2(FINE_N) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(COARSE_N - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FINE_N - 1);

  logic [CW-1:0] coarseIdx;
  logic [FW-1:0] fineIdx;

  // The fine index carries into, or borrows from, the coarse index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarseIdx <= '0;
      fineIdx   <= '0;
    end else if (cmd.step) begin
      if (cmd.up) begin
        if (fineIdx == F_LAST) begin
          fineIdx   <= '0;
          coarseIdx <= (coarseIdx == C_LAST) ? '0 : coarseIdx + 1'b1;
        end else begin
          fineIdx <= fineIdx + 1'b1;
        end
      end else begin
        if (fineIdx == '0) begin
          fineIdx   <= F_LAST;
          coarseIdx <= (coarseIdx == '0) ? C_LAST : coarseIdx - 1'b1;
        end else begin
          fineIdx <= fineIdx - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < COARSE_N; g++) begin : g_coarse
    assign coarseSel[g] = (coarseIdx == CW'(g));
  end
  for (genvar g = 0; g < FINE_N; g++) begin : g_fine
    assign fineSel[g] = (fineIdx == FW'(g));
  end
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq
  import pss_pkg::*;
#(
  parameter int MOD_W      = 7,
  parameter int MOD_PRESET = 83,
  parameter int COARSE_N   = 8,
  parameter int FINE_N     = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dirUp,
  input  logic                swallow,
  input  logic                modInc,
  input  logic                modDec,
  output logic                termPulse,
  output logic [MOD_W-1:0]    modVal,
  output logic [COARSE_N-1:0] coarseSel,
  output logic [FINE_N-1:0]   fineSel
);
  stepCmd_t cmd;

  pss_divider #(.MOD_W(MOD_W), .MOD_PRESET(MOD_PRESET)) u_div (
    .clk(clk), .rst_n(rst_n), .dirUp(dirUp), .swallow(swallow),
    .modInc(modInc), .modDec(modDec), .cmd(cmd),
    .termPulse(termPulse), .modVal(modVal)
  );

  pss_phase #(.COARSE_N(COARSE_N), .FINE_N(FINE_N)) u_phase (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .coarseSel(coarseSel), .fineSel(fineSel)
  );
endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
  parameter int MOD_W    = 7,
  parameter int COARSE_N = 8,
  parameter int FINE_N   = 25
) (
  input logic                clk,
  input logic                rst_n,
  input logic                modInc,
  input logic                modDec,
  input logic                termPulse,
  input logic [MOD_W-1:0]    modVal,
  input logic [COARSE_N-1:0] coarseSel,
  input logic [FINE_N-1:0]   fineSel
);
  // R8
  coarse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(coarseSel) == 1);
  // R8
  fine_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fineSel) == 1);
  // R9
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !termPulse |-> ($stable(coarseSel) && $stable(fineSel)));
  // R2
  term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (termPulse && modVal != MOD_W'(1)) |=> !termPulse);
  // R4
  mod_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modInc && !modDec) |=> (modVal == $past(modVal) + MOD_W'(1)));
  // R4
  mod_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modDec && !modInc) |=> (modVal == $past(modVal) - MOD_W'(1)));
  // R4
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modInc == modDec) |=> $stable(modVal));
endmodule

bind phase_step_seq pss_chk #(.MOD_W(MOD_W), .COARSE_N(COARSE_N), .FINE_N(FINE_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .modInc(modInc), .modDec(modDec),
  .termPulse(termPulse), .modVal(modVal),
  .coarseSel(coarseSel), .fineSel(fineSel)
);

// File: tb/phase_step_seq_bench.sv
`timescale 1ns/1ps
module phase_step_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dirUp = 1'b1;
  logic        swallow = 1'b0;
  logic        modInc = 1'b0;
  logic        modDec = 1'b0;
  logic        termPulse;
  logic [6:0]  modVal;
  logic [7:0]  coarseSel;
  logic [24:0] fineSel;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  phase_step_seq u_phase_step_seq (
    .clk(clk), .rst_n(rst_n), .dirUp(dirUp), .swallow(swallow),
    .modInc(modInc), .modDec(modDec), .termPulse(termPulse),
    .modVal(modVal), .coarseSel(coarseSel), .fineSel(fineSel)
  );

  // {dirUp, step count, expected phase afterwards}, starting from phase 0
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'd3,  8'd3},    // R6 plain advance
    {1'b1, 8'd22, 8'd25},   // R8 fine 24 carries into coarse 1
    {1'b0, 8'd1,  8'd24},   // R7 borrow from coarse 1
    {1'b0, 8'd24, 8'd0},
    {1'b0, 8'd1,  8'd199},  // R7 wrap 0 -> 199
    {1'b1, 8'd1,  8'd0},    // R6 wrap 199 -> 0
    {1'b0, 8'd50, 8'd150},
    {1'b1, 8'd49, 8'd199}
  };

  function automatic int phaseOf(logic [7:0] c, logic [24:0] f);
    int ci = -1;
    int fi = -1;
    if ($countones(c) != 1 || $countones(f) != 1) return -1;
    for (int i = 0; i < 8; i++) if (c[i]) ci = i;
    for (int i = 0; i < 25; i++) if (f[i]) fi = i;
    return ci * 25 + fi;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for n terminal pulses; report whether the phase moved off-pulse
  task automatic stepN(input int n, output bit held);
    int got = 0;
    int prev = phaseOf(coarseSel, fineSel);
    held = 1'b1;
    while (got < n) begin
      @(negedge clk);
      if (termPulse) got++;
      else if (phaseOf(coarseSel, fineSel) != prev) held = 1'b0;
      prev = phaseOf(coarseSel, fineSel);
    end
  endtask

  task automatic syncTerm();
    do @(negedge clk); while (!termPulse);
  endtask

  // Measure one period; action 1 = swallow, 2 = modDec, 3 = modInc at cycle `at`
  task automatic period(input int action, input int at, output int cyc, output bit narrow);
    syncTerm();
    cyc = 0;
    narrow = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && termPulse) narrow = 1'b0;
      if (cyc == at) begin
        swallow = (action == 1);
        modDec  = (action == 2);
        modInc  = (action == 3);
      end else begin
        swallow = 1'b0; modDec = 1'b0; modInc = 1'b0;
      end
      if (termPulse) break;
    end
    swallow = 1'b0; modDec = 1'b0; modInc = 1'b0;
  endtask

  task automatic pulseMod(input bit inc, input bit dec);
    @(negedge clk);
    modInc = inc; modDec = dec;
    @(negedge clk);
    modInc = 1'b0; modDec = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFail);
    $finish;
  end

  initial begin
    int cyc;
    bit flag;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(modVal == 7'd83, "R1 modulus", modVal, 83);
    chk(phaseOf(coarseSel, fineSel) == 0, "R1 phase", phaseOf(coarseSel, fineSel), 0);
    chk(termPulse == 1'b0, "R1 termPulse", termPulse, 0);

    // Vector walk of the selector
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dirUp = VEC[v][16];
      stepN(int'(VEC[v][15:8]), flag);
      chk(phaseOf(coarseSel, fineSel) == int'(VEC[v][7:0]),
          VEC[v][16] ? "R6/R8 up step" : "R7/R8 down step",
          phaseOf(coarseSel, fineSel), int'(VEC[v][7:0]));
      chk(flag, "R9 phase held between pulses", flag, 1);
    end

    // R2 plain period and pulse width
    period(0, 0, cyc, flag);
    chk(cyc == 83, "R2 period", cyc, 83);
    chk(flag, "R2 one-cycle pulse", flag, 1);

    // R3 swallow stretches one period
    period(1, 20, cyc, flag);
    chk(cyc == 84, "R3 stretched period", cyc, 84);
    period(0, 0, cyc, flag);
    chk(cyc == 83, "R3 next period normal", cyc, 83);

    // R5 mid-period modulus decrement used at the next compare
    period(2, 10, cyc, flag);
    chk(cyc == 82, "R5 mid-count change", cyc, 82);
    chk(modVal == 7'd82, "R4 modDec", modVal, 82);
    period(0, 0, cyc, flag);
    chk(cyc == 82, "R5 new modulus held", cyc, 82);

    // R4 increment and simultaneous pulses
    pulseMod(1'b1, 1'b0);
    chk(modVal == 7'd83, "R4 modInc", modVal, 83);
    pulseMod(1'b1, 1'b1);
    chk(modVal == 7'd83, "R4 both pulses", modVal, 83);
    pulseMod(1'b1, 1'b0);
    chk(modVal == 7'd84, "R4 modInc again", modVal, 84);
    period(0, 0, cyc, flag);
    period(0, 0, cyc, flag);
    chk(cyc == 84, "R2 period after increase", cyc, 84);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule